// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the time-multiplexed drive pattern for a quarter-duty liquid crystal panel with four common lines and eighteen segment lines, so up to 72 segments can be lit. It does not make voltages. Each pin gets a 2-bit level code, and an external resistor ladder or analog switch array turns that code into a voltage. The block steps through eight slots per frame. The first four slots select each common in turn. The last four repeat the same order with every level mirrored, so the panel sees no net DC.

A millisecond tick sets the pace. At 1/2 bias a slot lasts two ticks, so the frame repeats at 62.5 Hz. At 1/3 bias a slot lasts one tick, so the frame repeats at 125 Hz. A bias request takes effect only at a frame boundary. While the display is off, and from reset onward, every pin carries the non-selected waveform. This waveform still swaps polarity every half-frame, because the slot counter never stops.

Top module: `lcd_mux_seq`

## Requirements
- R1: The slot index counts from 0 to 7 and then wraps to 0. It advances after 2 ticks per slot at 1/2 bias and after 1 tick per slot at 1/3 bias. With no tick the slot does not change.
- R2: In slots 0-3 common (slot mod 4) is the selected common and drives code 2'b11. In slots 4-7 it drives 2'b00. At most one common is selected at a time.
- R3: Every unselected common drives 2'b01 in slots 0-3 and 2'b10 in slots 4-7. Level codes are: 00 ground, 01 lower bias, 10 upper bias, 11 full. At 1/2 bias both 01 and 10 mean the half level.
- R4: At 1/3 bias, a lit segment drives 00 in slots 0-3 and 11 in slots 4-7. An unlit segment drives 10 in slots 0-3 and 01 in slots 4-7.
- R5: At 1/2 bias, a lit segment drives 00 in slots 0-3 and 11 in slots 4-7. An unlit segment drives 11 in slots 0-3 and 00 in slots 4-7. Only 00 and 11 ever appear on segments.
- R6: Segment s is lit for common c when seg_data_i[s*4 + c] is 1.
- R7: The display-enable input is registered, so it acts from the next clock. While the display is disabled, every common drives its unselected level and every segment its unlit level. The slot counter keeps running, so the polarity still alternates.
- R8: A change on bias_third_i reaches the active bias only when the slot wraps from 7 to 0 on a slot-ending tick.
- R9: An asynchronous reset gives slot 0, the start of a slot, 1/2 bias active and the display disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | one-cycle pulse per millisecond |
| bias_third_i | input | 1 | bias request: 1 selects 1/3, 0 selects 1/2 |
| disp_on_i | input | 1 | display enable |
| seg_data_i | input | 72 | segment bits, index seg*4+com |
| com_lvl_o | output | 8 | 2-bit level code per common, common c at [2c+1:2c] |
| seg_lvl_o | output | 36 | 2-bit level code per segment, segment s at [2s+1:2s] |

## Verification
The assertions assume that tick_i is a single-cycle pulse and never arrives on back-to-back clocks. They also assume the clock is running when reset is released. The stimulus always drives tick_i high for exactly one cycle followed by a low cycle. The bias request and the display enable change only on the falling edge, away from any tick edge. The segment data is held steady across ticks and changes only between checks.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'b00,
    LVL_LO   = 2'b01,
    LVL_HI   = 2'b10,
    LVL_FULL = 2'b11
  } lvl_e;

  // second half-frame mirrors every level
  function automatic logic [1:0] lvl_mirror(lvl_e lvl, logic inv);
    return inv ? ~lvl : lvl;
  endfunction
endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int N_COM       = 4,
  parameter int TICKS_HALF  = 2,
  parameter int TICKS_THIRD = 1,
  localparam int SLOT_W     = $clog2(2 * N_COM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bias_third_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              third_o
);
  localparam int MAX_T     = (TICKS_HALF > TICKS_THIRD) ? TICKS_HALF : TICKS_THIRD;
  localparam int CNT_W     = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam int LAST_SLOT = 2 * N_COM - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_lim;
  logic [SLOT_W-1:0] slot_q;
  logic              third_q;
  logic              slot_end;

  assign cnt_lim  = third_q ? CNT_W'(TICKS_THIRD - 1) : CNT_W'(TICKS_HALF - 1);
  assign slot_end = tick_i && (cnt_q == cnt_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      slot_q  <= '0;
      third_q <= 1'b0;
    end else if (tick_i) begin
      if (slot_end) begin
        cnt_q <= '0;
        if (slot_q == SLOT_W'(LAST_SLOT)) begin
          slot_q  <= '0;
          third_q <= bias_third_i;  // bias swaps only at frame edge
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign slot_o  = slot_q;
  assign third_o = third_q;
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_seq_pkg::*;
#(
  parameter int N_COM   = 4,
  localparam int SLOT_W = $clog2(2 * N_COM),
  localparam int COM_W  = $clog2(N_COM)
) (
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               disp_i,
  output logic [2*N_COM-1:0] com_lvl_o
);
  logic [COM_W-1:0] com_idx;
  logic             inv;

  assign com_idx = slot_i[COM_W-1:0];
  assign inv     = slot_i[SLOT_W-1];

  for (genvar i = 0; i < N_COM; i++) begin : g_com
    logic sel;
    assign sel = disp_i && (com_idx == COM_W'(i));
    assign com_lvl_o[2*i +: 2] = lvl_mirror(sel ? LVL_FULL : LVL_LO, inv);
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_seq_pkg::*;
#(
  parameter int N_COM   = 4,
  parameter int N_SEG   = 18,
  localparam int SLOT_W = $clog2(2 * N_COM),
  localparam int COM_W  = $clog2(N_COM)
) (
  input  logic [SLOT_W-1:0]      slot_i,
  input  logic                   disp_i,
  input  logic                   third_i,
  input  logic [N_SEG*N_COM-1:0] data_i,
  output logic [2*N_SEG-1:0]     seg_lvl_o
);
  logic [COM_W-1:0] com_idx;
  logic             inv;
  lvl_e             off_lvl;

  assign com_idx = slot_i[COM_W-1:0];
  assign inv     = slot_i[SLOT_W-1];
  // 1/2 bias has no middle level on segments
  assign off_lvl = third_i ? LVL_HI : LVL_FULL;

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [N_COM-1:0] row;
    logic             lit;
    assign row = data_i[s*N_COM +: N_COM];
    assign lit = disp_i && row[com_idx];
    assign seg_lvl_o[2*s +: 2] = lvl_mirror(lit ? LVL_GND : off_lvl, inv);
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int N_COM       = 4,
  parameter int N_SEG       = 18,
  parameter int TICKS_HALF  = 2,
  parameter int TICKS_THIRD = 1,
  localparam int SLOT_W     = $clog2(2 * N_COM)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   bias_third_i,
  input  logic                   disp_on_i,
  input  logic [N_SEG*N_COM-1:0] seg_data_i,
  output logic [2*N_COM-1:0]     com_lvl_o,
  output logic [2*N_SEG-1:0]     seg_lvl_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              third_q;
  logic              disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) disp_q <= 1'b0;
    else         disp_q <= disp_on_i;
  end

  lcd_slot_timer #(
    .N_COM      (N_COM),
    .TICKS_HALF (TICKS_HALF),
    .TICKS_THIRD(TICKS_THIRD)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .bias_third_i(bias_third_i),
    .slot_o      (slot_q),
    .third_o     (third_q)
  );

  lcd_com_drv #(.N_COM(N_COM)) u_com (
    .slot_i   (slot_q),
    .disp_i   (disp_q),
    .com_lvl_o(com_lvl_o)
  );

  lcd_seg_drv #(.N_COM(N_COM), .N_SEG(N_SEG)) u_seg (
    .slot_i   (slot_q),
    .disp_i   (disp_q),
    .third_i  (third_q),
    .data_i   (seg_data_i),
    .seg_lvl_o(seg_lvl_o)
  );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int N_COM   = 4,
  parameter int N_SEG   = 18,
  localparam int SLOT_W = $clog2(2 * N_COM)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 disp_on_i,
  input logic [SLOT_W-1:0]    slot_q,
  input logic                 third_q,
  input logic [2*N_COM-1:0]   com_lvl_o,
  input logic [2*N_SEG-1:0]   seg_lvl_o
);
  localparam int LAST_SLOT = 2 * N_COM - 1;

  logic [N_COM-1:0] com_ext;  // common at an extreme level
  logic [N_COM-1:0] com_full;
  logic [N_SEG-1:0] seg_ext;

  always_comb begin
    for (int i = 0; i < N_COM; i++) begin
      com_ext[i]  = com_lvl_o[2*i] == com_lvl_o[2*i+1];
      com_full[i] = com_lvl_o[2*i +: 2] == 2'b11;
    end
    for (int s = 0; s < N_SEG; s++) seg_ext[s] = seg_lvl_o[2*s] == seg_lvl_o[2*s+1];
  end

  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(slot_q));  // R1
  AST_ONE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(com_ext) <= 1);  // R2
  AST_MIRROR_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q[SLOT_W-1] |-> (com_full == '0));  // R3
  AST_HALF_TWO_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !third_q |-> (&seg_ext));  // R5
  AST_BLANK_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(disp_on_i) |-> (com_ext == '0));  // R7
  AST_BIAS_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (third_q != $past(third_q)) |->
      (slot_q == '0 && $past(slot_q) == SLOT_W'(LAST_SLOT) && $past(tick_i)));  // R8
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .disp_on_i(disp_on_i),
  .slot_q   (slot_q),
  .third_q  (third_q),
  .com_lvl_o(com_lvl_o),
  .seg_lvl_o(seg_lvl_o)
);

// File: tb/sim_lcd_mux_seq.sv
module sim_lcd_mux_seq;
  localparam int NC = 4;
  localparam int NS = 18;
  localparam int NV = 15;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic           bias_third_i = 1'b1;
  logic           disp_on_i = 1'b0;
  logic [NS*NC-1:0] seg_data_i = 72'hA5_96C3_3C69_0FF0_1E2D;
  logic [2*NC-1:0]  com_lvl_o;
  logic [2*NS-1:0]  seg_lvl_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_mux_seq #(.N_COM(NC), .N_SEG(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .bias_third_i(bias_third_i),
    .disp_on_i(disp_on_i), .seg_data_i(seg_data_i),
    .com_lvl_o(com_lvl_o), .seg_lvl_o(seg_lvl_o)
  );

  // {bias request, ticks, expected slot, expected 1/3 active}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 4'd0, 3'd0, 1'b0},
    {1'b1, 4'd1, 3'd0, 1'b0},  // R1: half slot needs 2 ticks
    {1'b1, 4'd1, 3'd1, 1'b0},
    {1'b1, 4'd6, 3'd4, 1'b0},
    {1'b1, 4'd7, 3'd7, 1'b0},  // R8: still half bias
    {1'b1, 4'd1, 3'd0, 1'b1},  // R8: switch at wrap
    {1'b1, 4'd1, 3'd1, 1'b1},
    {1'b1, 4'd3, 3'd4, 1'b1},
    {1'b1, 4'd3, 3'd7, 1'b1},
    {1'b1, 4'd1, 3'd0, 1'b1},
    {1'b0, 4'd3, 3'd3, 1'b1},  // R8: request mid-frame held off
    {1'b0, 4'd4, 3'd7, 1'b1},
    {1'b0, 4'd1, 3'd0, 1'b0},
    {1'b0, 4'd1, 3'd0, 1'b0},
    {1'b0, 4'd1, 3'd1, 1'b0}
  };

  function automatic logic [2*NC-1:0] exp_com(logic [2:0] slot, logic disp);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      logic [1:0] v;
      v = (disp && c == int'(slot[1:0])) ? 2'b11 : 2'b01;
      r[2*c +: 2] = slot[2] ? ~v : v;
    end
    return r;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(logic [2:0] slot, logic third, logic disp,
                                              logic [NS*NC-1:0] d);
    logic [2*NS-1:0] r;
    for (int s = 0; s < NS; s++) begin
      logic [1:0] v;
      if (disp && d[s*NC + int'(slot[1:0])]) v = 2'b00;
      else v = third ? 2'b10 : 2'b11;
      r[2*s +: 2] = slot[2] ? ~v : v;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 R7: blank, half bias, slot 0
    check("R9 com reset", 72'(com_lvl_o), 72'(8'h55));
    check("R9 seg reset", 72'(seg_lvl_o), 72'({2*NS{1'b1}}));

    disp_on_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      bias_third_i = VEC[i][8];
      tick_n(int'(VEC[i][7:4]));
      check($sformatf("R1 R2 R3 com vec%0d", i), 72'(com_lvl_o),
            72'(exp_com(VEC[i][3:1], 1'b1)));
      check($sformatf("R4 R5 R8 seg vec%0d", i), 72'(seg_lvl_o),
            72'(exp_seg(VEC[i][3:1], VEC[i][0], 1'b1, seg_data_i)));
    end

    // R6: single lit bit, segment 5 on common 1 (slot 1, half bias)
    seg_data_i = '0;
    seg_data_i[5*NC + 1] = 1'b1;
    #1;
    check("R6 seg index", 72'(seg_lvl_o), 72'(36'hF_FFFF_F3FF));
    check("R2 com slot1", 72'(com_lvl_o), 72'(8'h5D));

    // R7: disable takes one clock, waveform keeps alternating
    @(negedge clk) disp_on_i = 1'b0;
    check("R7 before reg", 72'(seg_lvl_o), 72'(36'hF_FFFF_F3FF));
    @(negedge clk);
    check("R7 com off", 72'(com_lvl_o), 72'(8'h55));
    check("R7 seg off", 72'(seg_lvl_o), 72'({2*NS{1'b1}}));
    tick_n(6);
    check("R7 com off inv", 72'(com_lvl_o), 72'(8'hAA));
    check("R7 seg off inv", 72'(seg_lvl_o), 72'(36'h0));
    disp_on_i = 1'b1;
    @(negedge clk);
    check("R2 com slot4", 72'(com_lvl_o), 72'(8'hA8));
    check("R5 seg slot4", 72'(seg_lvl_o), 72'(36'h0));

    // R9: asynchronous reset mid-run
    bias_third_i = 1'b1;
    tick_n(3);
    rst_ni = 1'b0;
    #1;
    check("R9 com async", 72'(com_lvl_o), 72'(8'h55));
    check("R9 seg async", 72'(seg_lvl_o), 72'({2*NS{1'b1}}));
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check("R1 R9 com restart", 72'(com_lvl_o), 72'(8'h57));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule